// File: doc/BRIEF.md
# Slow-Reference Interval Timer with Match Interrupt

This block keeps a 24-bit count of rising edges on a slow (nominally 32 kHz) reference clock and presents it to software in the fast system clock domain. The slow clock is never used as a clock. It is sampled by a synchronizer. Every rising edge found in the system domain advances the count by one, so software only ever sees the count change at those detected edges.

Software reaches the block through a byte-wide register port. The count is read one byte at a time. Reading the least significant byte freezes a copy of the whole count, and the two upper bytes then come from that frozen copy, so the three bytes always belong together. A 24-bit match value is loaded in three byte writes and takes effect on the most significant byte. When the count steps onto the match value, a sticky flag is set. An enable bit decides whether that flag drives the interrupt line. A status bit mirrors the synchronized level of the slow clock, so software can wait for a fresh edge before it reads the count.

Top module: `sleep_timer_top`

## Requirements
- R1: After reset the count is 0, the match value is all ones (0xFFFFFF), the enable bit is 0, the flag is 0 and `irq` is low.
- R2: The count rises by exactly one for each rising edge of `slow_clk`. It is read at address 0 (bits 7:0), address 1 (bits 15:8) and address 2 (bits 23:16).
- R3: Status bit 1 at address 7 equals `slow_clk` delayed by two system clock edges. The count takes its new value on the third system clock edge after `slow_clk` rises.
- R4: A read at address 0 returns the live low byte and freezes the whole count. Reads at addresses 1 and 2 return the frozen bytes, and later increments do not change them until the next read at address 0.
- R5: Writes to addresses 3 (bits 7:0) and 4 (bits 15:8) only stage bytes. A write to address 5 (bits 23:16) loads all 24 match bits at once. Addresses 3 to 5 read back the active match value.
- R6: The flag (status bit 0 at address 7) is set in the cycle in which the count becomes equal to the match value. It is not set at any other time.
- R7: The flag stays set until software writes address 7 with bit 0 cleared. Writing bit 0 as 1 has no effect. If a match lands in the same cycle as a clearing write, the flag stays set.
- R8: `irq` is high exactly when the flag is set and the enable bit (bit 0 at address 6) is 1.
- R9: After all ones the count wraps to 0. The wrap raises no flag unless the match value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk | input | 1 | Slow reference clock, sampled as data |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; combinational from the address |
| irq | output | 1 | Match interrupt |

## Verification
The count is driven by single slow-clock edges, by one edge timed against the system clock edges, and by a long run of edges that carries into the middle byte. These cases separate a correct edge count from an off-by-one or a level-triggered count, and show whether a frozen snapshot differs from live upper bytes. The match logic is tested with staged byte writes and a commit, with matches taken with the enable off and on, and with a clearing write placed in the same cycle as a match. A reduced-width instance walks through a full wrap to show that rollover creates no event of its own.

// File: rtl/sleep_timer_pkg.sv
package sleep_timer_pkg;
    localparam int BYTE_W       = 8;
    localparam int STAT_FLAG_B  = 0;
    localparam int STAT_LEVEL_B = 1;
    localparam int CTRL_EN_B    = 0;
endpackage

// File: rtl/st_edge_sync.sv
module st_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign level_o = sh_q[STAGES-1];
    assign rise_o  = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R3: an edge yields a single-cycle pulse
    a_r3_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/st_counter.sv
module st_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             snap_req,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic [CNT_W-1:0] snap_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] snap;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick)     st_d.cnt  = st_q.cnt + CNT_W'(1);
        if (snap_req) st_d.snap = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o      = st_q.cnt;
    assign cnt_next_o = st_d.cnt;
    assign snap_o     = st_q.snap;

    // R2: the count moves only on a detected edge
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.cnt));
    // R4: the snapshot is frozen between low-byte reads
    a_r4_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> $stable(st_q.snap));
endmodule

// File: rtl/st_compare.sv
module st_compare
    import sleep_timer_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int NB    = CNT_W / BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic [NB-1:0]    byte_we,
    input  logic [7:0]       wdata,
    input  logic             en_we,
    input  logic             stat_we,
    output logic [CNT_W-1:0] cmp_o,
    output logic             flag_o,
    output logic             en_o
);
    typedef struct packed {
        logic [CNT_W-1:0] stage;
        logic [CNT_W-1:0] cmp;
        logic             flag;
        logic             en;
    } cmp_state_t;

    cmp_state_t       st_d, st_q;
    logic [CNT_W-1:0] commit;
    logic             match;

    always_comb begin
        st_d   = st_q;
        commit = st_q.stage;
        commit[CNT_W-BYTE_W +: BYTE_W] = wdata;
        match  = tick && (cnt_next == st_q.cmp);
        for (int i = 0; i < NB - 1; i++) begin
            if (byte_we[i]) st_d.stage[i*BYTE_W +: BYTE_W] = wdata;
        end
        if (byte_we[NB-1]) st_d.cmp = commit;
        if (en_we)         st_d.en  = wdata[CTRL_EN_B];
        if (stat_we && !wdata[STAT_FLAG_B]) st_d.flag = 1'b0;
        if (match)         st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.cmp   <= '1;
        end else begin
            st_q       <= st_d;
        end
    end

    assign cmp_o  = st_q.cmp;
    assign flag_o = st_q.flag;
    assign en_o   = st_q.en;

    // R6: stepping onto the match value sets the flag
    a_r6_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_next == st_q.cmp) |=> st_q.flag);
    // R6: the flag only rises on a count step
    a_r6_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(tick));
    // R7: without a write to status the flag holds
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !stat_we) |=> st_q.flag);
    // R5: the active match value changes only on a top-byte write
    a_r5_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_we[NB-1] |=> $stable(st_q.cmp));
endmodule

// File: rtl/sleep_timer_top.sv
module sleep_timer_top
    import sleep_timer_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_clk,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq
);
    localparam int NB     = CNT_W / BYTE_W;
    localparam int A_CMP  = NB;
    localparam int A_CTRL = 2 * NB;
    localparam int A_STAT = 2 * NB + 1;

    logic             lvl, tick, rd_stb, wr_stb, snap_req, en_we, stat_we;
    logic             flag, en;
    logic [NB-1:0]    byte_we;
    logic [CNT_W-1:0] cnt, cnt_next, snap, cmp;
    int               addr_i;

    assign addr_i   = int'(bus_addr);
    assign rd_stb   = bus_sel & ~bus_wr;
    assign wr_stb   = bus_sel & bus_wr;
    assign snap_req = rd_stb && (addr_i == 0);
    assign en_we    = wr_stb && (addr_i == A_CTRL);
    assign stat_we  = wr_stb && (addr_i == A_STAT);

    for (genvar g = 0; g < NB; g++) begin : g_cmp_we
        assign byte_we[g] = wr_stb && (addr_i == A_CMP + g);
    end

    st_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(slow_clk),
        .level_o(lvl), .rise_o(tick)
    );

    st_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .snap_req(snap_req),
        .cnt_o(cnt), .cnt_next_o(cnt_next), .snap_o(snap)
    );

    st_compare #(.CNT_W(CNT_W), .NB(NB)) u_cmp (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_next(cnt_next),
        .byte_we(byte_we), .wdata(bus_wdata), .en_we(en_we),
        .stat_we(stat_we), .cmp_o(cmp), .flag_o(flag), .en_o(en)
    );

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NB; i++) begin
            if (addr_i == i)
                bus_rdata = (i == 0) ? cnt[7:0] : snap[i*BYTE_W +: BYTE_W];
            if (addr_i == A_CMP + i)
                bus_rdata = cmp[i*BYTE_W +: BYTE_W];
        end
        if (addr_i == A_CTRL) bus_rdata[CTRL_EN_B] = en;
        if (addr_i == A_STAT) begin
            bus_rdata[STAT_FLAG_B]  = flag;
            bus_rdata[STAT_LEVEL_B] = lvl;
        end
    end

    assign irq = flag & en;
endmodule

// File: tb/sleep_timer_top_tb_top.sv
module sleep_timer_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_clk = 1'b0;
    logic       sel_m = 1'b0, sel_w = 1'b0, wr = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata_m, rdata_w;
    logic       irq_m, irq_w;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    sleep_timer_top dut_i (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .bus_sel(sel_m),
        .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata_m), .irq(irq_m)
    );

    sleep_timer_top #(.CNT_W(8)) dut_w (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .bus_sel(sel_w),
        .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata_w), .irq(irq_w)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input bit w, input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        sel_m = !w; sel_w = w; wr = 1'b0; addr = a;
        #1 d = w ? rdata_w : rdata_m;
        @(posedge clk); #1;
        sel_m = 1'b0; sel_w = 1'b0;
    endtask

    task automatic wrt(input bit w, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        sel_m = !w; sel_w = w; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        sel_m = 1'b0; sel_w = 1'b0; wr = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk) slow_clk = 1'b1;
        repeat (4) @(negedge clk);
        slow_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic read_cnt(output logic [23:0] c);
        logic [7:0] b0, b1, b2;
        rd(0, 3'd0, b0); rd(0, 3'd1, b1); rd(0, 3'd2, b2);
        c = {b2, b1, b0};
    endtask

    task automatic t_reset();
        logic [23:0] c; logic [7:0] d0, d1, d2;
        read_cnt(c);          chk("R1 count", c, 0);
        rd(0, 3'd3, d0); rd(0, 3'd4, d1); rd(0, 3'd5, d2);
        chk("R1 match value", {d2, d1, d0}, 24'hFFFFFF);
        rd(0, 3'd6, d0);      chk("R1 enable", d0, 0);
        rd(0, 3'd7, d0);      chk("R1 status", d0, 0);
        chk("R1 irq", irq_m, 0);
    endtask

    task automatic t_count();
        logic [23:0] c;
        repeat (3) pulse();
        read_cnt(c); chk("R2 three edges", c, 3);
    endtask

    task automatic t_timing();
        @(negedge clk); addr = 3'd7; slow_clk = 1'b1;
        @(posedge clk); #1 chk("R3 level after 1 edge", rdata_m[1], 0);
        @(posedge clk); #1 chk("R3 level after 2 edges", rdata_m[1], 1);
        addr = 3'd0;    #1 chk("R3 count before 3rd edge", rdata_m, 3);
        @(posedge clk); #1 chk("R3 count after 3rd edge", rdata_m, 4);
        repeat (3) @(negedge clk);
        slow_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_stage();
        logic [7:0] d;
        wrt(0, 3'd3, 8'h0A); wrt(0, 3'd4, 8'h00);
        rd(0, 3'd3, d); chk("R5 staged byte inactive", d, 8'hFF);
        wrt(0, 3'd5, 8'h00);
        rd(0, 3'd3, d); chk("R5 low after commit", d, 8'h0A);
        rd(0, 3'd5, d); chk("R5 high after commit", d, 8'h00);
    endtask

    task automatic t_match();
        logic [7:0] d;
        repeat (5) pulse();
        rd(0, 3'd7, d); chk("R6 no flag at 9", d[0], 0);
        pulse();
        rd(0, 3'd7, d); chk("R6 flag at 10", d[0], 1);
        chk("R8 irq masked", irq_m, 0);
        wrt(0, 3'd6, 8'h01);
        chk("R8 irq enabled", irq_m, 1);
    endtask

    task automatic t_clear();
        logic [7:0] d;
        wrt(0, 3'd7, 8'h01);
        rd(0, 3'd7, d); chk("R7 write 1 keeps flag", d[0], 1);
        pulse();
        rd(0, 3'd7, d); chk("R7 flag sticky", d[0], 1);
        wrt(0, 3'd7, 8'h00);
        rd(0, 3'd7, d); chk("R7 cleared", d[0], 0);
        chk("R8 irq low after clear", irq_m, 0);
        wrt(0, 3'd3, 8'h0C); wrt(0, 3'd5, 8'h00);
        wrt(0, 3'd7, 8'h01);
        rd(0, 3'd7, d); chk("R7 write 1 cannot set", d[0], 0);
        // collision: clearing write registered on the edge the count becomes 12
        @(negedge clk) slow_clk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        sel_m = 1'b1; wr = 1'b1; addr = 3'd7; wdata = 8'h00;
        @(posedge clk); #1 sel_m = 1'b0; wr = 1'b0;
        repeat (3) @(negedge clk);
        slow_clk = 1'b0;
        repeat (4) @(negedge clk);
        rd(0, 3'd7, d); chk("R7 match beats clear", d[0], 1);
        rd(0, 3'd0, d); chk("R7 count at collision", d, 8'h0C);
        wrt(0, 3'd7, 8'h00);
        wrt(0, 3'd6, 8'h00);
    endtask

    task automatic t_snapshot();
        logic [7:0] d;
        repeat (243) pulse();
        rd(0, 3'd0, d); chk("R4 low before carry", d, 8'hFF);
        pulse();
        rd(0, 3'd1, d); chk("R4 frozen middle", d, 8'h00);
        rd(0, 3'd2, d); chk("R4 frozen high", d, 8'h00);
        rd(0, 3'd0, d); chk("R4 new low", d, 8'h00);
        rd(0, 3'd1, d); chk("R4 new middle", d, 8'h01);
        rd(0, 3'd7, d); chk("R6 no stray flag", d[0], 0);
    endtask

    task automatic t_wrap();
        logic [7:0] d;
        wrt(1, 3'd1, 8'h80);
        repeat (255) pulse();
        rd(1, 3'd0, d); chk("R9 count at top", d, 8'hFF);
        rd(1, 3'd3, d); chk("R9 flag from 0x80 match", d[0], 1);
        wrt(1, 3'd3, 8'h00);
        pulse();
        rd(1, 3'd0, d); chk("R9 wrapped to zero", d, 8'h00);
        rd(1, 3'd3, d); chk("R9 wrap raises nothing", d[0], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_count();
        t_timing();
        t_stage();
        t_match();
        t_clear();
        t_snapshot();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule